// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

An eight-bit up-counter with one waveform output. The counter advances on ticks from a prescaler that divides the I/O clock by one of seven ratios. A zero select stops it. A two-bit mode input picks one of three ways of counting:

- **Free-running:** the counter wraps from 255 to 0.
- **Clear-on-match:** the counter restarts after it reaches the compare value. The output can toggle there, which gives a square wave of programmable frequency.
- **Single-slope pulse-width:** the counter runs 0..255. The output changes level at the compare point and at the wrap. Its polarity is set by the output-mode input.

Two sticky flags record the wrap event and the compare event. Software clears them by writing ones. A compare write port loads the compare value. A counter write port loads the count directly, and a compare match cannot occur on the tick right after such a load. In pulse-width mode the compare value passes through a holding register and takes effect only at the top of the count. This keeps every period glitch-free.

Top module: `wtmr8_timer`

## Requirements
- R1: `clk_sel` values 1..7 give a tick every 1, 8, 32, 64, 128, 256 or 1024 clock cycles. A value of 0 stops the counter, and no event or flag change follows.
- R2: With `mode_sel` 0 or 1, the counter runs 0..255 and wraps. The compare value never restarts it, so a wrap occurs every 256·N clock cycles.
- R3: With `mode_sel` 2, the counter returns to 0 on the tick after the one where it equals the compare value. With `out_mode` 1, `wave_out` toggles on each match, so each level lasts N·(1+compare) clock cycles.
- R4: Outside pulse-width mode, a compare write acts on the next tick. If the new value is below the current count, the next match comes only after the counter passes 255 and wraps.
- R5: `ovf_flag` is set by the tick on which the count goes from 255 to 0. This holds in all modes, including clear-on-match mode with a compare value of 255.
- R6: With `mode_sel` 3 and `out_mode` 2, `wave_out` is set at the wrap and cleared on the tick after count equals the compare value. It is therefore high for N·(compare+1) of every 256·N cycles.
- R7: With `mode_sel` 3 and `out_mode` 3, the polarity is inverted. `wave_out` is high for N·(255−compare) of every 256·N cycles.
- R8: In pulse-width mode, a compare write is held and takes effect only at the tick on which the count is 255. The running period keeps the old value.
- R9: `cmp_flag` is set by a tick on which the count equals the active compare value. A counter write suppresses the compare match on the next tick.
- R10: `out_mode` 0 holds `wave_out` at 0 in every mode. In pulse-width mode, `out_mode` 1 also holds it at 0.
- R11: Outside pulse-width mode, `out_mode` 2 drives `wave_out` to 0 on a match and `out_mode` 3 drives it to 1.
- R12: `flag_clr` bit 0 clears `ovf_flag` and bit 1 clears `cmp_flag`. A flag stays set until it is cleared, and clearing one flag leaves the other unchanged.
- R13: After reset the count and the compare value are 0, both flags are 0 and `wave_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0/1 free-running, 2 clear-on-match, 3 single-slope pulse-width |
| out_mode | input | 2 | Waveform action select (see R3, R6, R7, R10, R11) |
| clk_sel | input | 3 | Prescaler select, 0 stops |
| ocr_wr_en | input | 1 | Compare value write strobe |
| ocr_wr_data | input | 8 | Compare value |
| cnt_wr_en | input | 1 | Counter load strobe |
| cnt_wr_data | input | 8 | Counter load value |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 wrap flag, bit 1 compare flag |
| wave_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Sticky wrap flag |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The assertions check several rules on every cycle:

- the return to zero after a clear-on-match event and after a wrap
- the frozen compare value between pulse-width reloads
- the set and clear actions of the output at the wrap and at a match
- flag setting, write-one-to-clear behaviour, and the match suppression after a counter write
- the tick spacing of the prescaler

Only the bench scenarios can show the quantities that span whole periods. These are:

- the toggle half-period for each prescale ratio
- the duty cycle over a sweep of compare values in both polarities
- the long detour after a compare value is written below the count
- the exact cycle on which a held compare value first shapes the output

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;

  typedef enum logic [1:0] {
    WG_FREE     = 2'd0,
    WG_FREE_ALT = 2'd1,
    WG_CTC      = 2'd2,
    WG_FASTPWM  = 2'd3
  } wg_mode_e;

  localparam int PRE_W = 10;

  // Terminal value of the prescaler divider: ratio minus one.
  function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] sel);
    logic [PRE_W-1:0] lim;
    case (sel)
      3'd1:    lim = PRE_W'(0);
      3'd2:    lim = PRE_W'(7);
      3'd3:    lim = PRE_W'(31);
      3'd4:    lim = PRE_W'(63);
      3'd5:    lim = PRE_W'(127);
      3'd6:    lim = PRE_W'(255);
      3'd7:    lim = PRE_W'(1023);
      default: lim = PRE_W'(0);
    endcase
    return lim;
  endfunction

  // Next value of the counter after one tick.
  function automatic logic [7:0] next_count(input logic [7:0] cur, input logic restart);
    return restart ? 8'd0 : cur + 8'd1;
  endfunction

endpackage

// File: rtl/wtmr_prescaler.sv
module wtmr_prescaler
  import wtmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  output logic       tick
);

  logic [PRE_W-1:0] div_cnt;
  logic [PRE_W-1:0] lim;
  logic             run;

  assign run  = |clk_sel;
  assign lim  = div_limit(clk_sel);
  assign tick = run && (div_cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    div_cnt <= '0;
    else if (!run || div_cnt >= lim) div_cnt <= '0;
    else                           div_cnt <= div_cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clk_sel > 3'd1) |=> (!tick || clk_sel != $past(clk_sel))); // R1

endmodule

// File: rtl/wtmr_core.sv
module wtmr_core
  import wtmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       mode_sel,
  input  logic             ocr_wr_en,
  input  logic [CNT_W-1:0] ocr_wr_data,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  output logic             ev_match,
  output logic             ev_ovf,
  output logic             pwm_mode
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] ocr_buf;
  logic [CNT_W-1:0] ocr_act;
  logic             blk;
  logic             ctc_mode;
  logic             step;
  logic             ev_load;

  assign ctc_mode = (wg_mode_e'(mode_sel) == WG_CTC);
  assign pwm_mode = (wg_mode_e'(mode_sel) == WG_FASTPWM);
  assign step     = tick && !cnt_wr_en;
  assign ev_match = step && !blk && (count == ocr_act);
  assign ev_ovf   = step && (count == MAXV);
  assign ev_load  = ev_ovf && pwm_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count <= '0;
    else if (cnt_wr_en) count <= cnt_wr_data;
    else if (step)      count <= CNT_W'(next_count(8'(count), ctc_mode && ev_match));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         blk <= 1'b0;
    else if (cnt_wr_en) blk <= 1'b1;
    else if (step)      blk <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ocr_buf <= '0;
    else if (ocr_wr_en) ocr_buf <= ocr_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ocr_act <= '0;
    else if (pwm_mode) begin
      if (ev_load) ocr_act <= ocr_wr_en ? ocr_wr_data : ocr_buf;
    end else begin
      ocr_act <= ocr_wr_en ? ocr_wr_data : ocr_buf;
    end
  end

  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc_mode && ev_match) |=> (count == '0)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> (count == '0)); // R5
  AST_PWM_HOLD_OCR: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !ev_load) |=> $stable(ocr_act)); // R8

endmodule

// File: rtl/wtmr_wavegen.sv
module wtmr_wavegen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_mode,
  input  logic [1:0] out_mode,
  input  logic       ev_match,
  input  logic       ev_ovf,
  output logic       wave_out
);

  logic wave_q;
  logic wave_d;
  logic enable;

  always_comb begin
    wave_d = wave_q;
    if (pwm_mode) begin
      if (out_mode == 2'd2) begin
        if (ev_ovf)        wave_d = 1'b1;
        else if (ev_match) wave_d = 1'b0;
      end else if (out_mode == 2'd3) begin
        if (ev_ovf)        wave_d = 1'b0;
        else if (ev_match) wave_d = 1'b1;
      end
    end else if (ev_match) begin
      case (out_mode)
        2'd1:    wave_d = !wave_q;
        2'd2:    wave_d = 1'b0;
        2'd3:    wave_d = 1'b1;
        default: wave_d = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign enable   = pwm_mode ? out_mode[1] : (out_mode != 2'd0);
  assign wave_out = wave_q && enable;

  AST_PWM_BOTTOM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && out_mode == 2'd2 && ev_ovf) |=> wave_q); // R6
  AST_PWM_BOTTOM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && out_mode == 2'd3 && ev_ovf) |=> !wave_q); // R7
  AST_CTC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode && out_mode == 2'd1 && ev_match) |=> (wave_q != $past(wave_q))); // R3
  AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode && out_mode == 2'd3 && ev_match) |=> wave_q); // R11

endmodule

// File: rtl/wtmr8_timer.sv
module wtmr8_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       out_mode,
  input  logic [2:0]       clk_sel,
  input  logic             ocr_wr_en,
  input  logic [CNT_W-1:0] ocr_wr_data,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic [1:0]       flag_clr,
  output logic             wave_out,
  output logic             ovf_flag,
  output logic             cmp_flag
);

  logic tick;
  logic ev_match;
  logic ev_ovf;
  logic pwm_mode;

  wtmr_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_sel (clk_sel),
    .tick    (tick)
  );

  wtmr_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .mode_sel    (mode_sel),
    .ocr_wr_en   (ocr_wr_en),
    .ocr_wr_data (ocr_wr_data),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .ev_match    (ev_match),
    .ev_ovf      (ev_ovf),
    .pwm_mode    (pwm_mode)
  );

  wtmr_wavegen u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_mode (pwm_mode),
    .out_mode (out_mode),
    .ev_match (ev_match),
    .ev_ovf   (ev_ovf),
    .wave_out (wave_out)
  );

  // Sticky flags: a new event wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (ev_ovf)           ovf_flag <= 1'b1;
      else if (flag_clr[0]) ovf_flag <= 1'b0;
      if (ev_match)         cmp_flag <= 1'b1;
      else if (flag_clr[1]) cmp_flag <= 1'b0;
    end
  end

  AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> ovf_flag); // R5
  AST_CMP_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_match |=> cmp_flag); // R9
  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> !ev_match); // R9
  AST_OVF_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !ev_ovf) |=> !ovf_flag); // R12
  AST_CMP_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[1] && !ev_match) |=> !cmp_flag); // R12

endmodule

// File: tb/wtmr8_timer_tb_top.sv
module wtmr8_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [1:0] out_mode = 2'd0;
  logic [2:0] clk_sel = 3'd0;
  logic       ocr_wr_en = 1'b0;
  logic [7:0] ocr_wr_data = 8'd0;
  logic       cnt_wr_en = 1'b0;
  logic [7:0] cnt_wr_data = 8'd0;
  logic [1:0] flag_clr = 2'd0;
  logic       wave_out;
  logic       ovf_flag;
  logic       cmp_flag;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  wtmr8_timer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .out_mode(out_mode),
    .clk_sel(clk_sel), .ocr_wr_en(ocr_wr_en), .ocr_wr_data(ocr_wr_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .flag_clr(flag_clr),
    .wave_out(wave_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  function automatic int ratio(input int sel);
    case (sel)
      1: return 1;    2: return 8;    3: return 32;   4: return 64;
      5: return 128;  6: return 256;  7: return 1024;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int md, input int om, input int sel);
    @(negedge clk);
    rst_n = 1'b0;
    mode_sel = 2'(md); out_mode = 2'(om); clk_sel = 3'(sel);
    ocr_wr_en = 1'b0; cnt_wr_en = 1'b0; flag_clr = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_regs(input bit do_ocr, input int ov, input bit do_cnt, input int cv);
    ocr_wr_en = do_ocr; ocr_wr_data = 8'(ov);
    cnt_wr_en = do_cnt; cnt_wr_data = 8'(cv);
    @(negedge clk);
    ocr_wr_en = 1'b0; cnt_wr_en = 1'b0;
  endtask

  task automatic clr(input int bits);
    flag_clr = 2'(bits);
    @(negedge clk);
    flag_clr = 2'd0;
  endtask

  // Cycle stamp of the first negedge on which the chosen flag is seen set.
  task automatic wait_flag(input bit which_cmp, input int limit, output int t);
    t = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (which_cmp ? cmp_flag : ovf_flag) begin t = cyc; break; end
    end
  endtask

  task automatic wait_wave(input int limit, output int t);
    logic prev;
    prev = wave_out;
    t = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (wave_out != prev) begin t = cyc; break; end
    end
  endtask

  task automatic count_high(input int win, output int hi);
    hi = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (wave_out) hi++;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int t0, t1, t2, hi;

    // R13: reset state, first match at count 0 on the first tick, wrap at tick 256
    do_reset(0, 0, 1);
    t0 = cyc;
    check("R13 wave_out after reset", int'(wave_out), 0);
    check("R13 ovf_flag after reset", int'(ovf_flag), 0);
    check("R13 cmp_flag after reset", int'(cmp_flag), 0);
    wait_flag(1'b1, 50, t1);
    check("R13 first match from count 0 / compare 0", t1 - t0, 1);
    wait_flag(1'b0, 400, t1);
    check("R13 first wrap after reset", t1 - t0, 256);

    // R2: free-running wrap period for modes 0 and 1, compare does not restart
    for (int md = 0; md < 2; md++) begin
      for (int sel = 1; sel <= 3; sel++) begin
        do_reset(md, 0, sel);
        write_regs(1'b1, 10, 1'b0, 0);
        clr(1);
        wait_flag(1'b0, 20000, t1); clr(1);
        wait_flag(1'b0, 20000, t2);
        check($sformatf("R2 wrap period mode=%0d sel=%0d", md, sel), t2 - t1, 256 * ratio(sel));
      end
    end

    // R1 R3: clear-on-match toggle half period over every prescale ratio
    for (int sel = 1; sel <= 7; sel++) begin
      for (int k = 0; k < 2; k++) begin
        int v;
        v = (k == 0) ? 0 : 3;
        do_reset(2, 1, sel);
        write_regs(1'b1, v, 1'b1, 255);
        wait_wave(20000, t1);
        wait_wave(20000, t2);
        check($sformatf("R1 R3 half period sel=%0d cmp=%0d", sel, v), t2 - t1, ratio(sel) * (1 + v));
      end
    end
    for (int k = 0; k < 4; k++) begin
      int v;
      v = (k == 0) ? 17 : (k == 1) ? 100 : (k == 2) ? 254 : 255;
      do_reset(2, 1, 1);
      write_regs(1'b1, v, 1'b1, 255);
      wait_wave(2000, t1);
      wait_wave(2000, t2);
      check($sformatf("R3 half period sel=1 cmp=%0d", v), t2 - t1, 1 + v);
    end
    // R5: clear-on-match with compare 255 still raises the wrap flag every 256 ticks
    clr(1);
    wait_flag(1'b0, 600, t1); clr(1);
    wait_flag(1'b0, 600, t2);
    check("R5 wrap period in clear-on-match, cmp=255", t2 - t1, 256);

    // R4: compare written below the count misses and waits for the wrap
    do_reset(2, 1, 1);
    t0 = cyc;
    write_regs(1'b1, 50, 1'b1, 150);
    wait_flag(1'b0, 400, t1);
    check("R4 R5 wrap after missed match", t1 - t0, 107);
    wait_flag(1'b1, 400, t2);
    check("R4 missed match delayed to after wrap", t2 - t0, 158);
    // R4: compare above the count matches directly, then counter restarts
    do_reset(2, 1, 1);
    t0 = cyc;
    write_regs(1'b1, 200, 1'b1, 150);
    wait_flag(1'b1, 400, t1);
    check("R4 direct match", t1 - t0, 52);
    clr(2);
    wait_flag(1'b1, 400, t2);
    check("R3 restart period cmp=200", t2 - t1, 201);
    check("R5 no wrap while clear-on-match below 255", int'(ovf_flag), 0);

    // R9: a counter write suppresses the match on the next tick
    do_reset(2, 1, 1);
    t0 = cyc;
    write_regs(1'b1, 10, 1'b1, 9);
    wait_flag(1'b1, 50, t1);
    check("R9 match one tick after load", t1 - t0, 3);
    do_reset(2, 1, 1);
    t0 = cyc;
    write_regs(1'b1, 10, 1'b1, 10);
    check("R9 no match right after load", int'(cmp_flag), 0);
    wait_flag(1'b1, 400, t1);
    check("R9 blocked match returns after wrap", t1 - t0, 258);

    // R6: non-inverting pulse-width duty sweep
    do_reset(3, 2, 1);
    for (int v = 0; v < 256; v += 15) begin
      write_regs(1'b1, v, 1'b0, 0);
      repeat (520) @(negedge clk);
      count_high(256, hi);
      check($sformatf("R6 duty cmp=%0d", v), hi, v + 1);
    end
    write_regs(1'b1, 255, 1'b0, 0);
    repeat (520) @(negedge clk);
    count_high(256, hi);
    check("R6 duty cmp=255", hi, 256);

    // R7: inverting polarity
    do_reset(3, 3, 1);
    for (int k = 0; k < 4; k++) begin
      int v;
      v = (k == 0) ? 0 : (k == 1) ? 77 : (k == 2) ? 200 : 255;
      write_regs(1'b1, v, 1'b0, 0);
      repeat (520) @(negedge clk);
      count_high(256, hi);
      check($sformatf("R7 inverted duty cmp=%0d", v), hi, 255 - v);
    end
    // R1 R6 R7: prescale 8 scales the pulse widths
    do_reset(3, 2, 2);
    write_regs(1'b1, 40, 1'b0, 0);
    repeat (4200) @(negedge clk);
    count_high(2048, hi);
    check("R6 duty cmp=40 sel=2", hi, 8 * 41);
    out_mode = 2'd3;
    repeat (2100) @(negedge clk);
    count_high(2048, hi);
    check("R7 inverted duty cmp=40 sel=2", hi, 2048 - 8 * 41);

    // R8: held compare value in pulse-width mode
    do_reset(3, 2, 1);
    write_regs(1'b1, 200, 1'b0, 0);
    repeat (600) @(negedge clk);
    clr(1);
    wait_flag(1'b0, 400, t1);
    write_regs(1'b1, 20, 1'b0, 0);
    repeat (99) @(negedge clk);
    check("R8 old compare still in force (high)", int'(wave_out), 1);
    repeat (150) @(negedge clk);
    check("R8 old compare ends pulse at 200", int'(wave_out), 0);
    repeat (16) @(negedge clk);
    check("R8 next period starts high", int'(wave_out), 1);
    repeat (20) @(negedge clk);
    check("R8 new compare ends pulse at 20", int'(wave_out), 0);

    // R10: output disconnected
    do_reset(2, 0, 1);
    write_regs(1'b1, 3, 1'b1, 255);
    count_high(100, hi);
    check("R10 out_mode 0 in clear-on-match", hi, 0);
    do_reset(3, 1, 1);
    write_regs(1'b1, 100, 1'b0, 0);
    count_high(600, hi);
    check("R10 out_mode 1 in pulse-width", hi, 0);

    // R11: set and clear on match outside pulse-width mode
    do_reset(2, 3, 1);
    write_regs(1'b1, 5, 1'b1, 255);
    repeat (20) @(negedge clk);
    check("R11 set on match", int'(wave_out), 1);
    repeat (20) @(negedge clk);
    check("R11 stays set after more matches", int'(wave_out), 1);
    out_mode = 2'd2;
    repeat (20) @(negedge clk);
    check("R11 clear on match", int'(wave_out), 0);

    // R12 R1: sticky flags, separate clears, stopped prescaler
    do_reset(0, 0, 1);
    write_regs(1'b1, 10, 1'b0, 0);
    repeat (300) @(negedge clk);
    clk_sel = 3'd0;
    repeat (5) @(negedge clk);
    check("R12 ovf_flag sticky", int'(ovf_flag), 1);
    check("R12 cmp_flag sticky", int'(cmp_flag), 1);
    clr(1);
    check("R12 ovf_flag cleared by bit 0", int'(ovf_flag), 0);
    check("R12 cmp_flag kept by bit 0 clear", int'(cmp_flag), 1);
    clr(2);
    check("R12 cmp_flag cleared by bit 1", int'(cmp_flag), 0);
    repeat (3000) @(negedge clk);
    check("R1 stopped: no wrap", int'(ovf_flag), 0);
    check("R1 stopped: no match", int'(cmp_flag), 0);
    clk_sel = 3'd1;
    wait_flag(1'b0, 300, t1);
    check("R1 counting resumes", int'(t1 > 0), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule